// File: doc/BRIEF.md
# Dual-Output Programmable Clock Divider

This block takes one fast master clock and produces two slower clocks from it. Output 0 comes either straight from the master clock or from a power-of-two prescaler. Output 1 always passes through its own power-of-two prescaler. After that it either leaves directly or goes through a programmable integer divider whose divisor is the 10-bit programmed word plus two.

Each output has an enable request and a drive flag. The drive flag stands in for an output buffer that can be released to high impedance. Outputs start synchronously, with a latency that depends only on the setting. They stop only after the output has gone low. A new ratio takes effect only at the end of the output period in progress, so no period is ever cut short. Register decode, storage of the settings and power sequencing sit outside this block.

Every division ratio other than one is built from counters clocked by the master clock. A ratio of one passes the master clock through an AND gate. The gate is opened and closed on the falling edge.

Top module: `clkdiv_dual`

## Requirements
- R1: Each prescaler code selects a divide factor: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R2: With `out0Sel`=1, output 0 has a period of the prescaler factor in master cycles. With `out0Sel`=0 it carries the master clock itself.
- R3: With `divBypass`=0, output 1 has a period of M1·(W+2) master cycles, where M1 is its prescaler factor and W is `divWord`.
- R4: With `divBypass`=1, output 1 has a period of M1 master cycles, and `divWord` has no effect on it.
- R5: An enable request seen at a master rising edge raises the drive flag at that edge. For ratios above one, the output's first high phase also starts at that edge. For a ratio of one, the output's first high phase starts at the following edge. The first high phase has full length.
- R6: In every period of P master cycles the output is high first and then low. For output 0 and for output 1 in bypass, the high time is P/2. With the divider in the path, the high time is M1·floor((W+2)/2).
- R7: After the request is withdrawn, the drive flag falls only at an edge where the output was already low. While the drive flag is low, the output stays low.
- R8: A change of prescaler code, divide word, bypass or source select while an output runs takes effect only once the current period has completed. The next period starts with the new ratio.
- R9: During reset both outputs and both drive flags are low.
- R10: A ratio of one gives the master clock gated by an enable that changes only while the master clock is low, so no partial pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pre0Code | input | 2 | Prescaler code for output 0 |
| pre1Code | input | 2 | Prescaler code for output 1 |
| divWord | input | 10 | Divide word for output 1 (divisor = word + 2) |
| divBypass | input | 1 | 1: output 1 skips the divider |
| out0Sel | input | 1 | 1: output 0 from prescaler, 0: master clock |
| en0Req | input | 1 | Enable request for output 0 |
| en1Req | input | 1 | Enable request for output 1 |
| clkOut0 | output | 1 | Output clock 0 |
| clkOut1 | output | 1 | Output clock 1 |
| drive0 | output | 1 | Drive flag for output 0 (0 models high-Z) |
| drive1 | output | 1 | Drive flag for output 1 (0 models high-Z) |

## Verification
The hardest situation to reach is a ratio change that lands in the middle of a running period. The old period must still finish at full length before the new ratio starts. The bench enables output 1 and lets it run. It then rewrites the divide word on a falling edge a few cycles into a period, once shrinking the ratio and once growing it. A cycle model in the bench recomputes the expected waveform from the period arithmetic. Disabling at arbitrary phases, including the unity-ratio gated path, covers the low-before-release rule.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Strobes from a channel's control FSM to its datapath; at most one per cycle
  typedef struct packed {
    logic start;    // load ratio, restart phase
    logic advance;  // step phase, reload ratio at terminal count
    logic quiet;    // close unity-ratio gate
    logic clear;    // return datapath to idle
  } chanStrobe_t;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RUN  = 2'd1,
    ST_STOP = 2'd2
  } chanState_t;

endpackage

// File: rtl/clkdivRatio.sv
`timescale 1ns/1ps
module clkdivRatio #(
  parameter int PRE_W = 2,
  parameter int DIV_W = 10,
  parameter int CNT_W = 14
) (
  input  logic [PRE_W-1:0] preCode,
  input  logic [DIV_W-1:0] divWord,
  input  logic             usePre,
  input  logic             useDiv,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] highLen
);

  logic [CNT_W-1:0] preFactor;
  logic [CNT_W-1:0] divisor;
  logic [CNT_W-1:0] divHalf;

  always_comb begin
    preFactor = CNT_W'(1) << preCode;
    divisor   = CNT_W'(divWord) + CNT_W'(2);
    divHalf   = divisor >> 1;
    if (!usePre) begin
      period  = CNT_W'(1);
      highLen = '0;
    end else if (useDiv) begin
      period  = preFactor * divisor;
      highLen = preFactor * divHalf;
    end else begin
      period  = preFactor;
      highLen = preFactor >> 1;
    end
  end

endmodule

// File: rtl/chanCtrl.sv
`timescale 1ns/1ps
module chanCtrl
  import clkdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enReq,
  input  logic        outLevel,
  input  logic        isOne,
  output chanStrobe_t stb,
  output logic        drive
);

  chanState_t state, stateNext;
  logic       driveNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    driveNext = drive;
    unique case (state)
      ST_OFF: begin
        if (enReq) begin
          stb.start = 1'b1;
          stateNext = ST_RUN;
          driveNext = 1'b1;
        end
      end
      ST_RUN: begin
        if (enReq) begin
          stb.advance = 1'b1;
        end else if (isOne) begin
          stb.quiet = 1'b1;
          stateNext = ST_STOP;
        end else if (!outLevel) begin
          stb.clear = 1'b1;
          stateNext = ST_OFF;
          driveNext = 1'b0;
        end else begin
          stb.advance = 1'b1;
        end
      end
      ST_STOP: begin
        stb.clear = 1'b1;
        stateNext = ST_OFF;
        driveNext = 1'b0;
      end
      default: begin
        stateNext = ST_OFF;
        driveNext = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_OFF;
      drive <= 1'b0;
    end else begin
      state <= stateNext;
      drive <= driveNext;
    end
  end

endmodule

// File: rtl/chanPath.sv
`timescale 1ns/1ps
module chanPath
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobe_t      stb,
  input  logic [CNT_W-1:0] newPeriod,
  input  logic [CNT_W-1:0] newHigh,
  output logic             outLevel,
  output logic             atTc,
  output logic             isOne,
  output logic             clkOut
);

  logic [CNT_W-1:0] curPeriod;
  logic [CNT_W-1:0] curHigh;
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] phaseInc;
  logic             runOne;
  logic             gateLow;
  logic             reload;

  assign phaseInc = phase + CNT_W'(1);
  assign atTc     = (phase == curPeriod - CNT_W'(1));
  assign isOne    = (curPeriod == CNT_W'(1));
  assign reload   = stb.start | (stb.advance & atTc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPeriod <= CNT_W'(1);
      curHigh   <= '0;
      phase     <= '0;
      outLevel  <= 1'b0;
      runOne    <= 1'b0;
    end else if (stb.clear) begin
      phase    <= '0;
      outLevel <= 1'b0;
      runOne   <= 1'b0;
    end else if (stb.quiet) begin
      runOne <= 1'b0;
    end else if (reload) begin
      curPeriod <= newPeriod;
      curHigh   <= newHigh;
      phase     <= '0;
      outLevel  <= (newHigh != '0);
      runOne    <= (newPeriod == CNT_W'(1));
    end else if (stb.advance) begin
      phase    <= phaseInc;
      outLevel <= (phaseInc < curHigh);
    end
  end

  // Gate for the unity ratio only moves while clk is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateLow <= 1'b0;
    else       gateLow <= runOne;
  end

  assign clkOut = (clk & gateLow) | outLevel;

endmodule

// File: rtl/clkdiv_dual.sv
`timescale 1ns/1ps
module clkdiv_dual
  import clkdiv_pkg::*;
#(
  parameter int PRE_W = 2,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] pre0Code,
  input  logic [PRE_W-1:0] pre1Code,
  input  logic [DIV_W-1:0] divWord,
  input  logic             divBypass,
  input  logic             out0Sel,
  input  logic             en0Req,
  input  logic             en1Req,
  output logic             clkOut0,
  output logic             clkOut1,
  output logic             drive0,
  output logic             drive1
);

  localparam int NUM_OUT    = 2;
  localparam int MAX_PRE    = 1 << ((1 << PRE_W) - 1);
  localparam int MAX_PERIOD = MAX_PRE * ((1 << DIV_W) + 1);
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

  logic [PRE_W-1:0] preCode [NUM_OUT];
  logic             usePre  [NUM_OUT];
  logic             useDiv  [NUM_OUT];
  logic             enReq   [NUM_OUT];
  logic             clkOut  [NUM_OUT];
  logic             drive   [NUM_OUT];

  assign preCode[0] = pre0Code;
  assign preCode[1] = pre1Code;
  assign usePre[0]  = out0Sel;
  assign usePre[1]  = 1'b1;
  assign useDiv[0]  = 1'b0;
  assign useDiv[1]  = ~divBypass;
  assign enReq[0]   = en0Req;
  assign enReq[1]   = en1Req;
  assign clkOut0    = clkOut[0];
  assign clkOut1    = clkOut[1];
  assign drive0     = drive[0];
  assign drive1     = drive[1];

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] highLen;
    chanStrobe_t      stb;
    logic             outLevel;
    logic             atTc;
    logic             isOne;

    clkdivRatio #(.PRE_W(PRE_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_ratio (
      .preCode (preCode[g]),
      .divWord (divWord),
      .usePre  (usePre[g]),
      .useDiv  (useDiv[g]),
      .period  (period),
      .highLen (highLen)
    );

    chanCtrl u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .enReq    (enReq[g]),
      .outLevel (outLevel),
      .isOne    (isOne),
      .stb      (stb),
      .drive    (drive[g])
    );

    chanPath #(.CNT_W(CNT_W)) u_path (
      .clk       (clk),
      .rstN      (rstN),
      .stb       (stb),
      .newPeriod (period),
      .newHigh   (highLen),
      .outLevel  (outLevel),
      .atTc      (atTc),
      .isOne     (isOne),
      .clkOut    (clkOut[g])
    );
  end

endmodule

// File: rtl/clkdivChanChk.sv
`timescale 1ns/1ps
module clkdivChanChk
  import clkdiv_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        enReq,
  input logic        outLevel,
  input logic        isOne,
  input chanStrobe_t stb,
  input logic        drive
);

  // R7
  release_when_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drive) |-> !$past(outLevel));

  // R7
  idle_output_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !drive |-> !outLevel);

  // R7
  prompt_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drive && !enReq && !outLevel && !isOne) |=> !drive);

  // R5
  start_needs_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drive) |-> $past(enReq));

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R10
  gate_close_unity_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.quiet |-> isOne);

endmodule

bind chanCtrl clkdivChanChk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enReq    (enReq),
  .outLevel (outLevel),
  .isOne    (isOne),
  .stb      (stb),
  .drive    (drive)
);

// File: tb/tb_clkdiv_dual.sv
`timescale 1ns/1ps
module tb_clkdiv_dual;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pre0Code = '0, pre1Code = '0;
  logic [9:0] divWord = '0;
  logic       divBypass = 1'b0, out0Sel = 1'b1;
  logic       en0Req = 1'b0, en1Req = 1'b0;
  logic       clkOut0, clkOut1, drive0, drive1;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  clkdiv_dual dut (
    .clk(clk), .rstN(rstN), .pre0Code(pre0Code), .pre1Code(pre1Code),
    .divWord(divWord), .divBypass(divBypass), .out0Sel(out0Sel),
    .en0Req(en0Req), .en1Req(en1Req), .clkOut0(clkOut0), .clkOut1(clkOut1),
    .drive0(drive0), .drive1(drive1)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected period and high time from the requirements
  function automatic int tgtPeriod(input int ch);
    int m;
    if (ch == 0) return out0Sel ? (1 << pre0Code) : 1;
    m = 1 << pre1Code;
    return divBypass ? m : m * (int'(divWord) + 2);
  endfunction

  function automatic int tgtHigh(input int ch);
    int m;
    if (ch == 0) return out0Sel ? ((1 << pre0Code) / 2) : 0;
    m = 1 << pre1Code;
    return divBypass ? m / 2 : m * ((int'(divWord) + 2) / 2);
  endfunction

  function automatic logic outOf(input int ch);
    return (ch == 0) ? clkOut0 : clkOut1;
  endfunction

  function automatic logic drvOf(input int ch);
    return (ch == 0) ? drive0 : drive1;
  endfunction

  task automatic setEn(input int ch, input logic v);
    if (ch == 0) en0Req = v; else en1Req = v;
  endtask

  // Enable a channel, compare len master cycles against a phase model,
  // optionally rewrite divWord after sample chgAt, then disable.
  task automatic runCase(input int ch, input int len, input int chgAt,
                         input int chgWord, input string req);
    int p = 0, mT = 1, mH = 0, bad = 0, badAct = 0, badExp = 0, waitN = 0;
    logic expHi, expLo;
    @(negedge clk);
    setEn(ch, 1'b1);
    for (int j = 0; j < len; j++) begin
      @(posedge clk); #1;
      if (j == 0 || p == mT - 1) begin
        p = 0; mT = tgtPeriod(ch); mH = tgtHigh(ch);
      end else begin
        p++;
      end
      if (mT == 1) begin
        expHi = (j > 0);
        expLo = 1'b0;
      end else begin
        expHi = (p < mH);
        expLo = expHi;
      end
      if (bad == 0 && (outOf(ch) !== expHi || drvOf(ch) !== 1'b1)) begin
        bad = 1; badAct = {outOf(ch), drvOf(ch)}; badExp = {expHi, 1'b1};
      end
      @(negedge clk);
      if (j == chgAt) divWord = 10'(chgWord);
      #1;
      if (bad == 0 && outOf(ch) !== expLo) begin
        bad = 1; badAct = outOf(ch); badExp = expLo;
      end
    end
    check(bad == 0, req, badAct, badExp);
    // Disable: drive must drop only with the output low (R7)
    setEn(ch, 1'b0);
    waitN = 0;
    do begin
      @(posedge clk); #1;
      waitN++;
    end while (drvOf(ch) === 1'b1 && waitN < mT + 4);
    check(drvOf(ch) === 1'b0 && outOf(ch) === 1'b0, "R7 release", waitN,
          mH + 2);
    bad = 0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      if (outOf(ch) !== 1'b0 || drvOf(ch) !== 1'b0) bad = 1;
      @(negedge clk); #1;
      if (outOf(ch) !== 1'b0) bad = 1;
    end
    check(bad == 0, "R7 idle low", bad, 0);
  endtask

  initial begin : watchdog
    #(4 * 195000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int words[6] = '{0, 1, 2, 3, 6, 9};
    int t;
    // R9: reset state
    repeat (3) @(negedge clk);
    #1;
    check({clkOut0, clkOut1, drive0, drive1} === 4'b0, "R9", 
          {clkOut0, clkOut1, drive0, drive1}, 0);
    @(posedge clk); #1;
    check({clkOut0, clkOut1, drive0, drive1} === 4'b0, "R9",
          {clkOut0, clkOut1, drive0, drive1}, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1 R2 R10: output 0 over every code and both sources
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 2; s++) begin
        pre0Code = 2'(c);
        out0Sel  = 1'(s);
        runCase(0, 3 * tgtPeriod(0) + 4, -1, 0, s ? "R1 R2 R5 R6" : "R2 R10");
      end
    end

    // R3 R4 R6: output 1 over codes, words and bypass
    for (int c = 0; c < 4; c++) begin
      for (int w = 0; w < 6; w++) begin
        for (int b = 0; b < 2; b++) begin
          pre1Code  = 2'(c);
          divWord   = 10'(words[w]);
          divBypass = 1'(b);
          t = tgtPeriod(1);
          runCase(1, 3 * t + 4, -1, 0, b ? "R4 R10" : "R3 R6");
        end
      end
    end

    // R3 R4: largest divide word, divided and bypassed
    pre1Code = 2'd1; divWord = 10'd1023; divBypass = 1'b0;
    runCase(1, 2 * tgtPeriod(1) + 3, -1, 0, "R3 max word");
    pre1Code = 2'd3; divBypass = 1'b1;
    runCase(1, 3 * tgtPeriod(1) + 3, -1, 0, "R4 word ignored");

    // R8: mid-period ratio changes, shrinking then growing
    pre1Code = 2'd0; divBypass = 1'b0; divWord = 10'd8;
    runCase(1, 40, 3, 2, "R8 shrink");
    pre1Code = 2'd1; divWord = 10'd1;
    runCase(1, 60, 1, 7, "R8 grow");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule